// File: doc/BRIEF.md
# Configuration Request Retry Engine

This block sits in a PCIe root-complex bridge between the host-side port that issues configuration accesses and the transaction-layer send and completion paths. It takes one configuration read or write at a time and keeps its register offset, byte enables, direction and write data. It sends the request and waits for the completion. If an endpoint answers with Configuration Request Retry Status, the block sends the identical request again after a fixed pause, and the host does not see the retry. It keeps doing this until the endpoint answers with something else or the retry budget runs out.

One case is left to software. When the host has enabled retry-status visibility and the request is a read that covers the identification word at offset zero, the block does not retry. It returns a fabricated value whose low half is 0x0001 and whose other bits are all ones, and it reports the completion as successful. Other completion statuses, such as unsupported request or completer abort, go straight to the host with no retry.

The pause between attempts and the number of retries are parameters counted in clock cycles. The defaults are 125 cycles (one microsecond at 125 MHz) and 1000 retries.

Top module: `cfg_retry_engine`

## Requirements
- R1: `host_req_ready` is high only when no request is in flight. A request is accepted on a cycle where `host_req_valid` and `host_req_ready` are both high. No further request is accepted until its response has been delivered.
- R2: The cycle after acceptance, `tx_valid` rises and carries the accepted offset, byte enables, direction and write data. These stay unchanged until a cycle with `tx_ready` high.
- R3: Completion status encoding on `cpl_status` and `host_rsp_status`:
  - 0 is success.
  - 1 is unsupported request.
  - 2 is retry status.
  - 4 is completer abort.
  
  A completion with any status other than 2 is returned with its data and status in a single-cycle `host_rsp_valid` pulse. The pulse comes in the cycle after the completion is presented.
- R4: A completion with status 2 that is not covered by R6 makes the block send the identical request again. `host_rsp_valid` stays low until the final outcome.
- R5: After a status-2 completion that leads to a resend, `tx_valid` rises again exactly RETRY_GAP+1 clock cycles after the cycle in which the completion was presented.
- R6: A request is an identification read when all of these hold:
  - it is a read (`host_req_write`=0);
  - its offset is 0;
  - at least one of `host_req_be[1:0]` is set.
  
  If `crs_vis_en` is 1 and such a read gets status 2, it is not resent. The response carries data 0xFFFF0001 and status 0.
- R7: With `crs_vis_en`=1, a status-2 completion for a write, or for a read at any other offset or with `host_req_be[1:0]`=0, is still retried as in R4.
- R8: The block sends a request again at most MAX_RETRY times. If the completion of the last allowed attempt still has status 2, the response has status 4 and data of all ones for a read or zero for a write. `host_rsp_timeout` is high for that one response cycle only.
- R9: After reset, the outputs are as follows:
  - `host_req_ready` is high;
  - `tx_valid` is low;
  - `host_rsp_valid` is low;
  - `host_rsp_timeout` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crs_vis_en | input | 1 | Retry-status visibility enable from the root control setting |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Engine idle, request can be taken |
| host_req_write | input | 1 | 1 = configuration write, 0 = read |
| host_req_addr | input | ADDR_W | Dword register offset |
| host_req_be | input | DATA_W/8 | Byte enables |
| host_req_wdata | input | DATA_W | Write data |
| host_rsp_valid | output | 1 | Final response pulse |
| host_rsp_data | output | DATA_W | Response data |
| host_rsp_status | output | 3 | Response status (encoding in R3) |
| host_rsp_timeout | output | 1 | Retry budget exhausted |
| tx_valid | output | 1 | Request to transaction layer valid |
| tx_ready | input | 1 | Transaction layer takes the request |
| tx_write | output | 1 | Request direction |
| tx_addr | output | ADDR_W | Request offset |
| tx_be | output | DATA_W/8 | Request byte enables |
| tx_wdata | output | DATA_W | Request write data |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status |
| cpl_data | input | DATA_W | Completion data |

## Verification
The assertions assume that the completion path presents exactly one completion for each accepted send, and only while the engine is waiting for it. The assertions do not cover a completion that arrives unprompted or a second completion for the same send. The bench endpoint arms a single completion, two cycles after each send it observes, so stimulus never breaks this. The bench endpoint also withholds `tx_ready` on a repeating pattern, so sends are stalled at varied points relative to the retry pause.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef enum logic [2:0] {
    CPL_OK  = 3'd0,
    CPL_UR  = 3'd1,
    CPL_CRS = 3'd2,
    CPL_CA  = 3'd4
  } cpl_stat_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_DELAY
  } eng_state_e;

  typedef enum logic [1:0] {
    ACT_PASS,
    ACT_SYNTH,
    ACT_RETRY,
    ACT_EXPIRE
  } cpl_act_e;

  // A read that covers the identification halfword at offset zero.
  function automatic logic vendor_probe(input logic is_write, input logic off_zero,
                                        input logic [1:0] be_lo);
    return !is_write && off_zero && (|be_lo);
  endfunction

  // What to do with a completion that arrives while waiting.
  function automatic cpl_act_e classify(input logic [2:0] st, input logic vis_en,
                                        input logic vendor, input logic spent);
    if (st != CPL_CRS) return ACT_PASS;
    if (vis_en && vendor) return ACT_SYNTH;
    if (spent) return ACT_EXPIRE;
    return ACT_RETRY;
  endfunction

endpackage

// File: rtl/cfgr_gap_timer.sv
module cfgr_gap_timer #(
  parameter int GAP = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int W = (GAP < 2) ? 1 : $clog2(GAP + 1);
  localparam logic [W-1:0] START = W'(GAP - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= START;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R5: the pause counts down one step per cycle once started
  a_r5_gap_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cfgr_retry_budget.sv
module cfgr_retry_budget #(
  parameter int MAX_RETRY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic exhausted
);
  localparam int CW = $clog2(MAX_RETRY + 2);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

  logic [CW-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used <= '0;
    else if (clear) used <= '0;
    else if (bump) used <= used + 1'b1;
  end

  assign exhausted = (used == LIMIT);

  // R8: the engine never asks for a retry beyond the budget
  a_r8_no_bump_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> !exhausted);
  a_r8_budget_bound: assert property (@(posedge clk) disable iff (!rst_n)
    used <= LIMIT);
endmodule

// File: rtl/cfg_retry_engine.sv
module cfg_retry_engine
  import cfgr_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int RETRY_GAP = 125,
  parameter int MAX_RETRY = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                crs_vis_en,
  input  logic                host_req_valid,
  output logic                host_req_ready,
  input  logic                host_req_write,
  input  logic [ADDR_W-1:0]   host_req_addr,
  input  logic [DATA_W/8-1:0] host_req_be,
  input  logic [DATA_W-1:0]   host_req_wdata,
  output logic                host_rsp_valid,
  output logic [DATA_W-1:0]   host_rsp_data,
  output logic [2:0]          host_rsp_status,
  output logic                host_rsp_timeout,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic                tx_write,
  output logic [ADDR_W-1:0]   tx_addr,
  output logic [DATA_W/8-1:0] tx_be,
  output logic [DATA_W-1:0]   tx_wdata,
  input  logic                cpl_valid,
  input  logic [2:0]          cpl_status,
  input  logic [DATA_W-1:0]   cpl_data
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [DATA_W-1:0] SYNTH_VAL = {{(DATA_W-16){1'b1}}, 16'h0001};

  eng_state_e state_q, state_d;
  logic              write_q, vendor_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;

  // Named internal events
  logic     accept, tx_fire, cpl_take, spent, gap_done;
  logic     retry_fire, synth_fire, expire_fire, pass_fire;
  cpl_act_e act;

  assign host_req_ready = (state_q == ST_IDLE);
  assign accept   = host_req_valid && host_req_ready;
  assign tx_valid = (state_q == ST_SEND);
  assign tx_fire  = tx_valid && tx_ready;
  assign cpl_take = (state_q == ST_WAIT) && cpl_valid;
  assign act      = classify(cpl_status, crs_vis_en, vendor_q, spent);

  assign retry_fire  = cpl_take && (act == ACT_RETRY);
  assign synth_fire  = cpl_take && (act == ACT_SYNTH);
  assign expire_fire = cpl_take && (act == ACT_EXPIRE);
  assign pass_fire   = cpl_take && (act == ACT_PASS);

  assign tx_write = write_q;
  assign tx_addr  = addr_q;
  assign tx_be    = be_q;
  assign tx_wdata = wdata_q;

  cfgr_gap_timer #(.GAP(RETRY_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(retry_fire), .expired(gap_done));

  cfgr_retry_budget #(.MAX_RETRY(MAX_RETRY)) u_budget (
    .clk(clk), .rst_n(rst_n), .clear(accept), .bump(retry_fire), .exhausted(spent));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SEND;
      ST_SEND:  if (tx_fire) state_d = ST_WAIT;
      ST_WAIT:  if (cpl_take) state_d = retry_fire ? ST_DELAY : ST_IDLE;
      ST_DELAY: if (gap_done) state_d = ST_SEND;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  // Request holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q  <= 1'b0;
      vendor_q <= 1'b0;
      addr_q   <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      write_q  <= host_req_write;
      vendor_q <= vendor_probe(host_req_write, host_req_addr == '0, host_req_be[1:0]);
      addr_q   <= host_req_addr;
      be_q     <= host_req_be;
      wdata_q  <= host_req_wdata;
    end
  end

  // Final response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rsp_valid   <= 1'b0;
      host_rsp_data    <= '0;
      host_rsp_status  <= CPL_OK;
      host_rsp_timeout <= 1'b0;
    end else begin
      host_rsp_valid   <= synth_fire || expire_fire || pass_fire;
      host_rsp_timeout <= expire_fire;
      if (synth_fire) begin
        host_rsp_data   <= SYNTH_VAL;
        host_rsp_status <= CPL_OK;
      end else if (expire_fire) begin
        host_rsp_data   <= write_q ? '0 : '1;
        host_rsp_status <= CPL_CA;
      end else if (pass_fire) begin
        host_rsp_data   <= cpl_data;
        host_rsp_status <= cpl_status;
      end
    end
  end

  // Input assumption: one completion per send, only while waiting
  a_cpl_only_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (state_q == ST_WAIT));
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !host_req_ready);
  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_addr) && $stable(tx_be)
                                 && $stable(tx_wdata) && $stable(tx_write)));
  a_r3_rsp_follows_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> $past(cpl_valid));
  a_r4_retry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    retry_fire |=> !host_rsp_valid);
  a_r5_no_early_resend: assert property (@(posedge clk) disable iff (!rst_n)
    retry_fire |=> !tx_valid);
  a_r6_never_crs_out: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> (host_rsp_status != CPL_CRS));
  a_r8_timeout_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_timeout |-> host_rsp_valid);
  a_r8_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_timeout |=> !host_rsp_timeout);
endmodule

// File: tb/tb_cfg_retry_engine.sv
module tb_cfg_retry_engine;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int GAP    = 4;
  localparam int MAXR   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crs_vis_en = 1'b0;
  logic host_req_valid = 1'b0, host_req_ready, host_req_write = 1'b0;
  logic [ADDR_W-1:0] host_req_addr = '0;
  logic [3:0] host_req_be = '0;
  logic [31:0] host_req_wdata = '0;
  logic host_rsp_valid, host_rsp_timeout;
  logic [31:0] host_rsp_data;
  logic [2:0] host_rsp_status;
  logic tx_valid, tx_ready = 1'b0, tx_write;
  logic [ADDR_W-1:0] tx_addr;
  logic [3:0] tx_be;
  logic [31:0] tx_wdata;
  logic cpl_valid = 1'b0;
  logic [2:0] cpl_status = '0;
  logic [31:0] cpl_data = '0;

  always #4 clk = ~clk;

  cfg_retry_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RETRY_GAP(GAP), .MAX_RETRY(MAXR)) dut (
    .clk(clk), .rst_n(rst_n), .crs_vis_en(crs_vis_en),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_addr(host_req_addr),
    .host_req_be(host_req_be), .host_req_wdata(host_req_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_data(host_rsp_data),
    .host_rsp_status(host_rsp_status), .host_rsp_timeout(host_rsp_timeout),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_write(tx_write), .tx_addr(tx_addr),
    .tx_be(tx_be), .tx_wdata(tx_wdata),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data));

  int checks = 0, failures = 0;
  int cyc = 0, cd = 0, sends = 0, rsp_cnt = 0, crs_cyc = 0;
  int ep_crs = 0;
  logic [2:0] ep_status = 3'd0;
  bit gap_armed = 0, tx_prev = 0;
  logic cur_w = 1'b0;
  logic [ADDR_W-1:0] cur_a = '0;
  logic [3:0] cur_be = '0;
  logic [31:0] cur_wd = '0;
  logic [31:0] got_data = '0;
  logic [2:0] got_status = '0;
  logic got_to = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Endpoint model: answers each send two cycles later, retry status for the first ep_crs sends
  always @(negedge clk) begin
    cyc++;
    if (cpl_valid) cpl_valid = 1'b0;
    tx_ready = ((cyc % 3) != 1);
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        cpl_valid  = 1'b1;
        cpl_status = (sends <= ep_crs) ? 3'd2 : ep_status;
        cpl_data   = {16'hA5C3, 8'(cur_a), 8'(sends)};
        if (cpl_status == 3'd2) begin crs_cyc = cyc; gap_armed = 1; end
      end
    end
    if (tx_valid && !tx_prev && gap_armed) begin
      check(cyc - crs_cyc == GAP + 1, "R5 resend spacing", cyc - crs_cyc, GAP + 1);
      gap_armed = 0;
    end
    tx_prev = tx_valid;
    if (tx_valid && tx_ready) begin
      sends++;
      check(tx_addr == cur_a && tx_be == cur_be && tx_write == cur_w && tx_wdata == cur_wd,
            "R2/R4 sent fields", {tx_write, tx_addr, tx_be}, {cur_w, cur_a, cur_be});
      cd = 2;
    end
    if (host_rsp_valid) begin
      rsp_cnt++;
      got_data = host_rsp_data;
      got_status = host_rsp_status;
      got_to = host_rsp_timeout;
    end
  end

  task automatic run_txn(input logic w, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                         input logic v, input int k, input logic [2:0] s);
    bit vendor, synth, expire;
    int n = 0;
    int exp_sends;
    logic [31:0] exp_data;
    logic [2:0] exp_st;
    @(negedge clk);
    ep_crs = k; ep_status = s; sends = 0; rsp_cnt = 0; gap_armed = 0;
    cur_w = w; cur_a = a; cur_be = be; cur_wd = 32'h1234_0000 ^ {26'd0, a};
    crs_vis_en = v;
    host_req_write = w; host_req_addr = a; host_req_be = be; host_req_wdata = cur_wd;
    host_req_valid = 1'b1;
    @(negedge clk);
    host_req_valid = 1'b0;
    check(!host_req_ready, "R1 ready low while busy", host_req_ready, 0);
    while (rsp_cnt == 0 && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    check(rsp_cnt == 1, "R1/R4 single response", rsp_cnt, 1);
    check(!host_rsp_timeout, "R8 timeout one cycle", host_rsp_timeout, 0);
    check(host_req_ready, "R1 ready after response", host_req_ready, 1);
    vendor = !w && a == '0 && (be[0] || be[1]);
    synth  = (k > 0) && vendor && v;
    expire = !synth && (k > MAXR);
    if (synth) begin
      exp_sends = 1; exp_data = 32'hFFFF0001; exp_st = 3'd0;
    end else if (expire) begin
      exp_sends = MAXR + 1; exp_data = w ? 32'h0 : 32'hFFFFFFFF; exp_st = 3'd4;
    end else begin
      exp_sends = k + 1; exp_data = {16'hA5C3, 8'(a), 8'(k + 1)}; exp_st = s;
    end
    check(sends == exp_sends, synth ? "R6 no retry" : (expire ? "R8 send bound" : "R4/R7 send count"),
          sends, exp_sends);
    check(got_data == exp_data, synth ? "R6 synthesized data" : (expire ? "R8 data" : "R3 data"),
          got_data, exp_data);
    check(got_status == exp_st, synth ? "R6 status" : (expire ? "R8 status" : "R3 status"),
          got_status, exp_st);
    check(got_to == expire, "R8 timeout flag", got_to, expire);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(host_req_ready && !tx_valid && !host_rsp_valid && !host_rsp_timeout,
          "R9 reset state", {host_req_ready, tx_valid, host_rsp_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_req_ready && !tx_valid && !host_rsp_valid, "R9 after release",
          {host_req_ready, tx_valid, host_rsp_valid}, 3'b100);
    for (int w = 0; w < 2; w++)
      for (int ai = 0; ai < 2; ai++)
        for (int bi = 0; bi < 2; bi++)
          for (int v = 0; v < 2; v++)
            for (int k = 0; k <= MAXR + 2; k++)
              run_txn(w[0], ai ? ADDR_W'(5) : '0, bi ? 4'hC : 4'hF, v[0], k, 3'd0);
    // R3 pass-through of other statuses, with and without prior retries
    run_txn(1'b0, '0, 4'hF, 1'b0, 0, 3'd1);
    run_txn(1'b0, ADDR_W'(9), 4'hF, 1'b1, 2, 3'd1);
    run_txn(1'b1, ADDR_W'(3), 4'h1, 1'b0, 1, 3'd4);
    // R6 with only the upper identification byte enabled
    run_txn(1'b0, '0, 4'h2, 1'b1, 1, 3'd0);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule